// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog counter that advances on its own tick enable, which keeps running while the core clock is stopped. An 8-stage binary prescaler is shared with a general-purpose timer. When the assignment input selects the watchdog, the prescaler divides the watchdog's wrap events. When it selects the timer, the prescaler divides the timer's tick and returns the divided tick on a dedicated output. A 3-bit select picks the division ratio as a power of two, from 1 to 128.

A time-out is reported in one of two ways. If the device is awake, the block raises a one-cycle reset request. If the device is asleep, it raises a one-cycle wake-up request instead. In both cases the active-low time-out flag goes low. A clear command or a sleep-entry command restarts the watchdog. The prescaler is restarted as well, but only when it is assigned to the watchdog. A configuration enable input, when low, stops all watchdog time-outs.

All logic runs on one fast clock `clk`. Both ticks are single-cycle enables on `clk`. All outputs are registered and change one cycle after the event that causes them.

Top module: `wdog_shared_psc`

## Requirements
- R1: During and immediately after reset, `reset_req_o`, `wake_req_o` and `tmr_tick_o` are 0 and `tmo_n_o` is 1.
- R2: With `psa_i`=0 and the device awake, the 2^WIDTH-th watchdog tick after a clear produces a reset request. The request is a pulse exactly one cycle long. No pulse appears before that tick.
- R3: With `psa_i`=1 and `ratio_i`=k, a time-out occurs on the (2^WIDTH · 2^k)-th watchdog tick after a clear, and not earlier.
- R4: With `psa_i`=0 and `ratio_i`=k, `tmr_tick_o` pulses once every 2^k timer ticks, evenly spaced. With `psa_i`=1, `tmr_tick_o` repeats every `tmr_tick_i` pulse, undivided.
- R5: With `psa_i`=1, a clear restarts both the watchdog counter and the prescaler, so a full divided period follows the clear.
- R6: With `psa_i`=0, a clear leaves the prescaler count untouched, so the phase of `tmr_tick_o` is unaffected.
- R7: A sleep-entry pulse restarts the watchdog counter (and the prescaler when assigned to it) in the same way as a clear.
- R8: A time-out while `asleep_i`=1 produces a one-cycle `wake_req_o` pulse and no reset request.
- R9: A time-out drives `tmo_n_o` to 0. It stays 0 until a clear or a reset returns it to 1.
- R10: While `wdt_en_i`=0, no time-out is ever produced, and the watchdog counter does not advance.
- R11: When a clear and a time-out fall in the same cycle, the clear wins. No request pulse is produced, `tmo_n_o` becomes 1, and the watchdog restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock for all logic |
| rst_n | input | 1 | Active-low power-on reset |
| tmr_tick_i | input | 1 | Timer tick enable from the core clock domain |
| wdt_tick_i | input | 1 | Free-running watchdog tick enable |
| clear_i | input | 1 | Watchdog clear command pulse |
| sleep_enter_i | input | 1 | Sleep-entry command pulse |
| asleep_i | input | 1 | 1 while the device is in sleep |
| wdt_en_i | input | 1 | Configuration enable; 0 disables the watchdog permanently |
| psa_i | input | 1 | Prescaler assignment: 1 = watchdog, 0 = timer |
| ratio_i | input | 3 | Division ratio select, divide by 2^ratio_i |
| reset_req_o | output | 1 | One-cycle reset request on an awake time-out |
| wake_req_o | output | 1 | One-cycle wake-up request on an asleep time-out |
| tmo_n_o | output | 1 | Time-out status flag, 0 after a time-out |
| tmr_tick_o | output | 1 | Tick returned to the timer (divided when unassigned) |

## Verification
The hardest situation to reach from the ports is a clear arriving in exactly the cycle in which the counter wraps. The bench reaches it by counting 2^WIDTH−1 ticks after a known clear and then raising the tick and the clear together. It then checks that the next time-out needs a full fresh period.

The second hard case is showing that a clear does not touch an unassigned prescaler, since the prescaler count is never visible. The bench first locks onto the phase of `tmr_tick_o` by waiting for a pulse. It then places a clear in mid-period and confirms that the next pulse arrives on the original schedule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Registered outputs of the watchdog top level
    typedef struct packed {
        logic rst_req;
        logic wake_req;
        logic tmo_n;
        logic tmr_out;
    } wdog_out_t;

    localparam wdog_out_t WDOG_OUT_RST = '{rst_req: 1'b0, wake_req: 1'b0,
                                          tmo_n: 1'b1, tmr_out: 1'b0};

endpackage

// File: rtl/wdog_base_ctr.sv
module wdog_base_ctr #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic enable_i,
    input  logic flush_i,
    output logic wrap_o
);
    localparam logic [WIDTH-1:0] CNT_TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (flush_i) begin
            cnt_d = '0;
        end else if (enable_i && tick_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = (cnt_q == CNT_TOP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdog_psc.sv
module wdog_psc #(
    parameter int STAGES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      evt_i,
    input  logic                      flush_i,
    input  logic [$clog2(STAGES)-1:0] sel_i,
    output logic                      evt_o
);
    logic [STAGES-1:0] cnt_d, cnt_q;
    logic [STAGES-1:0] at_top;   // at_top[k]: low k bits all ones

    assign at_top[0] = 1'b1;
    for (genvar k = 1; k < STAGES; k++) begin : g_tap
        assign at_top[k] = at_top[k-1] & cnt_q[k-1];
    end

    always_comb begin
        cnt_d = cnt_q;
        evt_o = 1'b0;
        if (flush_i) begin
            cnt_d = '0;
        end else if (evt_i) begin
            cnt_d = cnt_q + 1'b1;
            evt_o = at_top[sel_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdog_shared_psc.sv
module wdog_shared_psc
    import wdog_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int PSC_STAGES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tmr_tick_i,
    input  logic                          wdt_tick_i,
    input  logic                          clear_i,
    input  logic                          sleep_enter_i,
    input  logic                          asleep_i,
    input  logic                          wdt_en_i,
    input  logic                          psa_i,
    input  logic [$clog2(PSC_STAGES)-1:0] ratio_i,
    output logic                          reset_req_o,
    output logic                          wake_req_o,
    output logic                          tmo_n_o,
    output logic                          tmr_tick_o
);
    wdog_out_t out_d, out_q;

    logic restart;     // clear or sleep entry
    logic base_wrap;
    logic psc_in;
    logic psc_flush;
    logic psc_evt;
    logic timeout;

    assign restart   = clear_i | sleep_enter_i;
    assign psc_in    = psa_i ? base_wrap : tmr_tick_i;
    assign psc_flush = psa_i & restart;

    wdog_base_ctr #(.WIDTH(WIDTH)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (wdt_tick_i),
        .enable_i (wdt_en_i),
        .flush_i  (restart),
        .wrap_o   (base_wrap)
    );

    wdog_psc #(.STAGES(PSC_STAGES)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (psc_in),
        .flush_i (psc_flush),
        .sel_i   (ratio_i),
        .evt_o   (psc_evt)
    );

    always_comb begin
        out_d          = out_q;
        out_d.rst_req  = 1'b0;
        out_d.wake_req = 1'b0;
        out_d.tmr_out  = psa_i ? tmr_tick_i : psc_evt;
        timeout        = wdt_en_i & ~restart & (psa_i ? psc_evt : base_wrap);
        if (clear_i) begin
            out_d.tmo_n = 1'b1;
        end else if (timeout) begin
            out_d.tmo_n = 1'b0;
            if (asleep_i) out_d.wake_req = 1'b1;
            else          out_d.rst_req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= WDOG_OUT_RST;
        else        out_q <= out_d;
    end

    assign reset_req_o = out_q.rst_req;
    assign wake_req_o  = out_q.wake_req;
    assign tmo_n_o     = out_q.tmo_n;
    assign tmr_tick_o  = out_q.tmr_out;

endmodule

// File: rtl/wdog_shared_psc_chk.sv
module wdog_shared_psc_chk (
    input logic clk,
    input logic rst_n,
    input logic tmr_tick_i,
    input logic clear_i,
    input logic asleep_i,
    input logic wdt_en_i,
    input logic psa_i,
    input logic reset_req_o,
    input logic wake_req_o,
    input logic tmo_n_o,
    input logic tmr_tick_o
);
    // R8
    wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> $past(asleep_i));

    // R2
    reset_only_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> !$past(asleep_i));

    // R2
    single_cycle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req_o || wake_req_o) |=> !(reset_req_o || wake_req_o));

    // R9
    flag_low_on_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req_o || wake_req_o) |-> !tmo_n_o);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wdt_en_i) |-> !(reset_req_o || wake_req_o));

    // R11
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (tmo_n_o && !reset_req_o && !wake_req_o));

    // R4
    bypass_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(psa_i) |-> (tmr_tick_o == $past(tmr_tick_i)));

endmodule

bind wdog_shared_psc wdog_shared_psc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_tick_i  (tmr_tick_i),
    .clear_i     (clear_i),
    .asleep_i    (asleep_i),
    .wdt_en_i    (wdt_en_i),
    .psa_i       (psa_i),
    .reset_req_o (reset_req_o),
    .wake_req_o  (wake_req_o),
    .tmo_n_o     (tmo_n_o),
    .tmr_tick_o  (tmr_tick_o)
);

// File: tb/wdog_shared_psc_tb.sv
module wdog_shared_psc_tb;
    localparam int WIDTH  = 8;
    localparam int PERIOD = 1 << WIDTH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_tick = 1'b0, wdt_tick = 1'b0, clear = 1'b0, sleep_enter = 1'b0;
    logic       asleep = 1'b0, wdt_en = 1'b1, psa = 1'b0;
    logic [2:0] ratio = 3'd0;
    logic       reset_req, wake_req, tmo_n, tmr_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    int exp_q[$];   // 1 = reset request, 2 = wake-up request

    always #4 clk = ~clk;

    wdog_shared_psc #(.WIDTH(WIDTH), .PSC_STAGES(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tmr_tick_i(tmr_tick), .wdt_tick_i(wdt_tick),
        .clear_i(clear), .sleep_enter_i(sleep_enter), .asleep_i(asleep),
        .wdt_en_i(wdt_en), .psa_i(psa), .ratio_i(ratio),
        .reset_req_o(reset_req), .wake_req_o(wake_req), .tmo_n_o(tmo_n),
        .tmr_tick_o(tmr_out)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wtick();
        wdt_tick = 1'b1;
        @(negedge clk);
        wdt_tick = 1'b0;
    endtask

    task automatic wticks(input int n);
        for (int i = 0; i < n; i++) wtick();
    endtask

    task automatic ttick();
        tmr_tick = 1'b1;
        @(negedge clk);
        tmr_tick = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic expect_evt(input int kind);
        exp_q.push_back(kind);
    endtask

    // Monitor: every request pulse must match the next queued expectation
    always @(negedge clk) begin
        if (mon_on && (reset_req || wake_req)) begin
            int got;
            got = (reset_req ? 1 : 0) + (wake_req ? 2 : 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R8 unexpected request", got, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(got == e, "R2/R8 request kind", got, e);
            end
        end
    end

    // Watchdog on the run length
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", cycles, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(reset_req == 0 && wake_req == 0 && tmr_out == 0 && tmo_n == 1,
            "R1 in reset", {reset_req, wake_req, tmr_out, tmo_n}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reset_req == 0 && wake_req == 0 && tmr_out == 0 && tmo_n == 1,
            "R1 after reset", {reset_req, wake_req, tmr_out, tmo_n}, 1);
        mon_on = 1'b1;

        // R2: unassigned prescaler, awake time-out
        psa = 1'b0; ratio = 3'd5;
        do_clear();
        wticks(PERIOD - 1);
        chk(tmo_n == 1, "R2 flag before wrap", tmo_n, 1);
        expect_evt(1);
        wtick();
        chk(reset_req == 1, "R2 reset on wrap", reset_req, 1);
        chk(tmo_n == 0, "R9 flag low after time-out", tmo_n, 0);
        @(negedge clk);
        chk(reset_req == 0, "R2 pulse one cycle", reset_req, 0);
        repeat (5) @(negedge clk);
        chk(tmo_n == 0, "R9 flag stays low", tmo_n, 0);
        do_clear();
        chk(tmo_n == 1, "R9 clear sets flag", tmo_n, 1);

        // R3: assigned prescaler, divide by 4
        psa = 1'b1; ratio = 3'd2;
        do_clear();
        wticks(4 * PERIOD - 1);
        chk(reset_req == 0, "R3 nothing before full period", reset_req, 0);
        expect_evt(1);
        wtick();
        chk(reset_req == 1, "R3 divided time-out", reset_req, 1);
        do_clear();

        // R5: clear restarts the assigned prescaler too
        psa = 1'b1; ratio = 3'd1;
        do_clear();
        wticks(300);
        do_clear();
        wticks(2 * PERIOD - 1);
        chk(reset_req == 0 && tmo_n == 1, "R5 full period after clear", tmo_n, 1);
        expect_evt(1);
        wtick();
        chk(reset_req == 1, "R5 time-out after restart", reset_req, 1);
        do_clear();

        // R7 / R8: sleep entry restarts, time-out while asleep wakes
        psa = 1'b0;
        do_clear();
        wticks(200);
        sleep_enter = 1'b1; asleep = 1'b1;
        @(negedge clk);
        sleep_enter = 1'b0;
        wticks(PERIOD - 1);
        chk(wake_req == 0 && reset_req == 0, "R7 sleep entry restarted counter", wake_req, 0);
        expect_evt(2);
        wtick();
        chk(wake_req == 1 && reset_req == 0, "R8 wake only", {reset_req, wake_req}, 1);
        chk(tmo_n == 0, "R9 flag low after wake", tmo_n, 0);
        asleep = 1'b0;
        do_clear();

        // R10: disabled watchdog never times out
        wdt_en = 1'b0;
        psa = 1'b1; ratio = 3'd0;
        wticks(3 * PERIOD);
        psa = 1'b0;
        wticks(3 * PERIOD);
        chk(tmo_n == 1 && reset_req == 0, "R10 disabled no time-out", tmo_n, 1);
        wdt_en = 1'b1;
        @(negedge clk);
        wticks(PERIOD - 1);
        chk(reset_req == 0, "R10 counter held while disabled", reset_req, 0);
        expect_evt(1);
        wtick();
        chk(reset_req == 1, "R10 counts again once enabled", reset_req, 1);

        // R11: clear coincides with the wrap
        psa = 1'b0;
        do_clear();
        wticks(PERIOD - 1);
        wdt_tick = 1'b1; clear = 1'b1;
        @(negedge clk);
        wdt_tick = 1'b0; clear = 1'b0;
        chk(reset_req == 0 && tmo_n == 1, "R11 clear wins", {reset_req, tmo_n}, 1);
        wticks(PERIOD - 1);
        chk(reset_req == 0, "R11 restarted from zero", reset_req, 0);
        expect_evt(1);
        wtick();
        chk(reset_req == 1, "R11 next full period", reset_req, 1);
        do_clear();

        // R4: divided timer tick when unassigned
        psa = 1'b0; ratio = 3'd3;
        @(negedge clk);
        begin
            int n_pulse = 0;
            int last = -1;
            bit even = 1'b1;
            for (int i = 0; i < 64; i++) begin
                ttick();
                if (tmr_out) begin
                    if (last >= 0 && i - last != 8) even = 1'b0;
                    last = i;
                    n_pulse++;
                end
            end
            chk(n_pulse == 8, "R4 pulse count divide by 8", n_pulse, 8);
            chk(even, "R4 pulse spacing", even, 1);
        end
        // R4: bypass when assigned to the watchdog
        psa = 1'b1;
        for (int i = 0; i < 3; i++) begin
            ttick();
            chk(tmr_out == 1, "R4 bypass tick", tmr_out, 1);
            @(negedge clk);
            chk(tmr_out == 0, "R4 bypass idle", tmr_out, 0);
        end

        // R6: clear does not touch an unassigned prescaler
        psa = 1'b0; ratio = 3'd3;
        @(negedge clk);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 16 && !seen; i++) begin
                ttick();
                if (tmr_out) seen = 1'b1;
            end
            chk(seen, "R6 phase lock", seen, 1);
        end
        ttick(); ttick(); ttick();
        do_clear();
        for (int i = 0; i < 4; i++) begin
            ttick();
            chk(tmr_out == 0, "R6 no early pulse", tmr_out, 0);
        end
        ttick();
        chk(tmr_out == 1, "R6 phase kept across clear", tmr_out, 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2/R8 all expected requests seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule